// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the bus-facing register file of an interrupt routing controller. A host reaches a small internal register space through two memory-mapped locations. It first writes an 8-bit pointer into the selector location. It then reads or writes a 32-bit word through the data location. The internal space holds the following:

- a controller identifier;
- a read-only revision word;
- a read-only arbitration word;
- a table of 64-bit routing entries, one for each interrupt input line.

Each routing entry is split across two consecutive pointer values. Every entry is exported in parallel to the interrupt evaluation logic. A one-cycle per-entry strobe tells that logic when an entry was rewritten.

The bus port takes one request per cycle. The read data and the error code are registered on the clock edge that takes the request. The error code returns to zero on any clock edge with no request. The read data holds its value until the next read. The number of lines is set by the parameter `NUM_LINES`, which may range from 1 to 120.

Top module: `irq_route_regwin`

## Requirements
- R1: Only byte offset 0x00 (selector) and 0x10 (data) in the 32-byte window are valid. Any other offset answers with error code 01 and changes no state. Error code 00 means no error.
- R2: A selector write keeps only bits 7:0 of the write data, whatever the access size. A selector read returns the stored value zero-extended.
- R3: A data write whose size code is not 2 answers with error code 10 and changes no state. Size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes.
- R4: Pointer 0 holds a 4-bit identifier in bits 27:24. It is written from those same bits, and every other bit reads zero.
- R5: Pointer 1 reads 0x11 in bits 7:0 and NUM_LINES-1 in bits 23:16, with zeros elsewhere. Writes to it have no effect.
- R6: Pointer 2 reads zero, and writes to it have no effect.
- R7: Entry n occupies pointer 0x10+2n for bits 31:0 and pointer 0x10+2n+1 for bits 63:32. A write to one half leaves the other half unchanged.
- R8: Entry writes pass only the writable bits. These are bits 11:0, 13, 15 and 16 of the low half, and bits 31:16 of the high half (entry bits 63:48). Status bits 12 and 14 and all reserved bits keep their value.
- R9: A pointer at or above 0x10 that lies past the last entry reads zero. Pointers 3 to 0x0F read 0xFFFFFFFF. Writes to either kind are ignored without error.
- R10: `entry_tbl[64n+63:64n]` always presents the current contents of entry n.
- R11: Synchronous reset clears the identifier and the selector. It sets every entry to 0x0000_0000_0001_0800, which is masked with logical destination mode.
- R12: An accepted write to either half of entry n raises `cfg_chg[n]` for exactly the one cycle after the write edge. No other strobe bit is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the window |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 2 | Registered error code |
| entry_tbl | output | 64*NUM_LINES | All routing entries, flattened |
| cfg_chg | output | NUM_LINES | Per-entry rewrite strobe |

## Verification
The bench targets the boundaries of the pointer space, where an off-by-one error shows up:

- the first pointer past the table, which must read zero rather than alias the last entry;
- the gap between 3 and 0x0F, which must read all ones.

The bench writes all ones to both halves of an entry. Status or reserved bits that leak through the write mask then appear in the read-back. It also writes one half and reads the other, which exposes a write that clobbers the whole 64-bit word.

The bench covers the rejection paths:

- an undersized data write, which must not change the entry;
- a bad offset.

The bench also checks the rewrite strobe:

- it must last exactly one cycle;
- it must be silent for writes to ignored pointers.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;
  localparam logic [7:0]  REV_CODE    = 8'h11;
  localparam logic [7:0]  PTR_ID      = 8'h00;
  localparam logic [7:0]  PTR_REV     = 8'h01;
  localparam logic [7:0]  PTR_ARB     = 8'h02;
  localparam logic [7:0]  PTR_TBL     = 8'h10;
  localparam logic [4:0]  OFF_SEL     = 5'h00;
  localparam logic [4:0]  OFF_DATA    = 5'h10;
  localparam logic [1:0]  SZ_WORD     = 2'd2;
  localparam logic [63:0] ENT_RESET   = 64'h0000_0000_0001_0800;
  localparam logic [63:0] ENT_WMASK   = 64'hFFFF_0000_0001_AFFF;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_REG  = 2'b01,
    ERR_SIZE = 2'b10
  } bus_err_t;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              sel_wr,
  output logic              data_wr,
  output logic              sel_rd,
  output logic              data_rd,
  output bus_err_t          err
);
  logic at_sel, at_data, size_ok;

  always_comb begin
    at_sel  = (addr == ADDR_W'(OFF_SEL));
    at_data = (addr == ADDR_W'(OFF_DATA));
    size_ok = (size == SZ_WORD);
    sel_wr  = req && we && at_sel;
    sel_rd  = req && !we && at_sel;
    data_wr = req && we && at_data && size_ok;
    data_rd = req && !we && at_data;
    if (!req)                          err = ERR_NONE;
    else if (!at_sel && !at_data)      err = ERR_REG;
    else if (at_data && we && !size_ok) err = ERR_SIZE;
    else                               err = ERR_NONE;
  end
endmodule

// File: rtl/regwin_entry.sv
module regwin_entry
  import irq_regwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [31:0] wdata,
  output logic [63:0] entry,
  output logic        chg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      entry <= ENT_RESET;
      chg   <= 1'b0;
    end else begin
      chg <= we_lo || we_hi;
      if (we_lo)
        entry[31:0] <= (entry[31:0] & ~ENT_WMASK[31:0]) | (wdata & ENT_WMASK[31:0]);
      if (we_hi)
        entry[63:32] <= (entry[63:32] & ~ENT_WMASK[63:32]) | (wdata & ENT_WMASK[63:32]);
    end
  end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
  import irq_regwin_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [1:0]              bus_size,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic [1:0]              bus_err,
  output logic [64*NUM_LINES-1:0] entry_tbl,
  output logic [NUM_LINES-1:0]    cfg_chg
);
  localparam logic [6:0] NUM_L7   = 7'(NUM_LINES);
  localparam logic [7:0] LAST_ENT = 8'(NUM_LINES - 1);

  logic       sel_wr, data_wr, sel_rd, data_rd;
  bus_err_t   err_c;
  logic [7:0] idx_q;
  logic [3:0] id_q;
  logic [7:0] tbl_off;
  logic [6:0] ent_num;
  logic       ent_half, in_tbl;
  logic [63:0] ent [NUM_LINES];
  logic [31:0] rd_word;

  regwin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .size(bus_size),
    .sel_wr(sel_wr), .data_wr(data_wr), .sel_rd(sel_rd), .data_rd(data_rd),
    .err(err_c)
  );

  always_comb begin
    tbl_off  = idx_q - PTR_TBL;
    ent_num  = tbl_off[7:1];
    ent_half = tbl_off[0];
    in_tbl   = (idx_q >= PTR_TBL) && (ent_num < NUM_L7);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ent
    logic hit;
    assign hit = data_wr && in_tbl && (ent_num == 7'(i));
    regwin_entry u_ent (
      .clk(clk), .rst(rst),
      .we_lo(hit && !ent_half), .we_hi(hit && ent_half),
      .wdata(bus_wdata), .entry(ent[i]), .chg(cfg_chg[i])
    );
    assign entry_tbl[64*i +: 64] = ent[i];
  end

  always_comb begin
    rd_word = 32'h0;
    if (idx_q == PTR_ID)       rd_word = {4'h0, id_q, 24'h0};
    else if (idx_q == PTR_REV) rd_word = {8'h0, LAST_ENT, 8'h0, REV_CODE};
    else if (idx_q == PTR_ARB) rd_word = 32'h0;
    else if (idx_q < PTR_TBL)  rd_word = 32'hFFFF_FFFF;
    else begin
      for (int i = 0; i < NUM_LINES; i++)
        if (in_tbl && ent_num == 7'(i))
          rd_word = ent_half ? ent[i][63:32] : ent[i][31:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= 8'h0;
      id_q      <= 4'h0;
      bus_rdata <= 32'h0;
      bus_err   <= ERR_NONE;
    end else begin
      bus_err <= err_c;
      if (sel_wr)  idx_q <= bus_wdata[7:0];
      if (data_wr && idx_q == PTR_ID) id_q <= bus_wdata[27:24];
      if (sel_rd)  bus_rdata <= {24'h0, idx_q};
      if (data_rd) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk
  import irq_regwin_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [1:0]           bus_size,
  input logic [1:0]           bus_err,
  input logic [NUM_LINES-1:0] cfg_chg,
  input logic [7:0]           idx_q
);
  a_r1_bad_offset: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_addr != ADDR_W'(OFF_SEL) && bus_addr != ADDR_W'(OFF_DATA))
      |=> (bus_err == 2'b01));

  a_r3_size_reject: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == ADDR_W'(OFF_DATA) && bus_size != SZ_WORD)
      |=> (bus_err == 2'b10));

  a_r2_selector_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we && bus_addr == ADDR_W'(OFF_SEL)) |=> $stable(idx_q));

  a_r12_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cfg_chg));

  a_r12_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> (cfg_chg == '0));
endmodule

bind irq_route_regwin regwin_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_err(bus_err),
  .cfg_chg(cfg_chg), .idx_q(idx_q)
);

// File: tb/sim_irq_route_regwin.sv
`timescale 1ns/1ps
module sim_irq_route_regwin;
  localparam int N = 24;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [1:0] bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] bus_err;
  logic [64*N-1:0] entry_tbl;
  logic [N-1:0] cfg_chg;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_route_regwin #(.NUM_LINES(N)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .entry_tbl(entry_tbl), .cfg_chg(cfg_chg)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic we, input logic [4:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output logic [1:0] er);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    rd = bus_rdata; er = bus_err;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic [31:0] rd; logic [1:0] er;
    xact(1'b1, 5'h00, 2'd0, {24'h0, p}, rd, er);
  endtask

  task automatic wr_data(input logic [31:0] v, output logic [1:0] er);
    logic [31:0] rd;
    xact(1'b1, 5'h10, 2'd2, v, rd, er);
  endtask

  task automatic rd_ptr(input logic [7:0] p, output logic [31:0] v);
    logic [1:0] er;
    set_ptr(p);
    xact(1'b0, 5'h10, 2'd2, 32'h0, v, er);
  endtask

  task automatic t_reset_state;
    logic [31:0] v; logic [1:0] er;
    xact(1'b0, 5'h00, 2'd0, 32'h0, v, er);
    chk("R11 selector after reset", v, 32'h0);
    rd_ptr(8'h00, v); chk("R11 id after reset", v, 32'h0);
    rd_ptr(8'h10, v); chk("R11 entry0 low", v, 32'h0001_0800);
    rd_ptr(8'h11, v); chk("R11 entry0 high", v, 32'h0);
    chk("R10 export entry last at reset", entry_tbl[64*(N-1) +: 64], 64'h0000_0000_0001_0800);
  endtask

  task automatic t_offsets;
    logic [31:0] v; logic [1:0] er;
    xact(1'b0, 5'h04, 2'd2, 32'h0, v, er); chk("R1 read offset 0x04 err", er, 2'b01);
    xact(1'b1, 5'h18, 2'd2, 32'hFF, v, er); chk("R1 write offset 0x18 err", er, 2'b01);
    xact(1'b0, 5'h00, 2'd0, 32'h0, v, er); chk("R1 selector untouched", v, 32'h11);
  endtask

  task automatic t_selector;
    logic [31:0] v; logic [1:0] er;
    xact(1'b1, 5'h00, 2'd2, 32'h1234_56AB, v, er);
    chk("R2 selector write no err", er, 2'b00);
    xact(1'b0, 5'h00, 2'd0, 32'h0, v, er);
    chk("R2 selector low byte", v, 32'h0000_00AB);
  endtask

  task automatic t_size;
    logic [31:0] v; logic [1:0] er;
    set_ptr(8'h14);
    xact(1'b1, 5'h10, 2'd0, 32'h0000_0055, v, er); chk("R3 byte write err", er, 2'b10);
    xact(1'b1, 5'h10, 2'd3, 32'h0000_0066, v, er); chk("R3 dword write err", er, 2'b10);
    rd_ptr(8'h14, v); chk("R3 entry2 unchanged", v, 32'h0001_0800);
  endtask

  task automatic t_id;
    logic [31:0] v; logic [1:0] er;
    set_ptr(8'h00); wr_data(32'hFFFF_FFFF, er);
    rd_ptr(8'h00, v); chk("R4 id field only", v, 32'h0F00_0000);
    set_ptr(8'h00); wr_data(32'h0500_0000, er);
    rd_ptr(8'h00, v); chk("R4 id rewrite", v, 32'h0500_0000);
  endtask

  task automatic t_rev_arb;
    logic [31:0] v; logic [1:0] er;
    logic [31:0] rev_exp;
    rev_exp = {8'h0, 8'(N-1), 8'h0, 8'h11};
    set_ptr(8'h01); wr_data(32'hDEAD_BEEF, er);
    rd_ptr(8'h01, v); chk("R5 revision word", v, rev_exp);
    set_ptr(8'h02); wr_data(32'hDEAD_BEEF, er);
    chk("R6 arb write no err", er, 2'b00);
    rd_ptr(8'h02, v); chk("R6 arb reads zero", v, 32'h0);
  endtask

  task automatic t_halves_mask;
    logic [31:0] v; logic [1:0] er;
    set_ptr(8'h16); wr_data(32'hFFFF_FFFF, er);
    rd_ptr(8'h16, v); chk("R8 low mask", v, 32'h0001_AFFF);
    rd_ptr(8'h17, v); chk("R7 high untouched by low write", v, 32'h0);
    set_ptr(8'h17); wr_data(32'hFFFF_FFFF, er);
    rd_ptr(8'h17, v); chk("R8 high mask", v, 32'hFFFF_0000);
    rd_ptr(8'h16, v); chk("R7 low untouched by high write", v, 32'h0001_AFFF);
    set_ptr(8'h16); wr_data(32'h0000_0042, er);
    rd_ptr(8'h16, v); chk("R8 clear low", v, 32'h0000_0042);
    chk("R10 export entry3", entry_tbl[64*3 +: 64], 64'hFFFF_0000_0000_0042);
  endtask

  task automatic t_bounds;
    logic [31:0] v; logic [1:0] er;
    logic [7:0] past;
    past = 8'(8'h10 + 2*N);
    rd_ptr(past, v); chk("R9 past table reads zero", v, 32'h0);
    rd_ptr(past - 8'd1, v); chk("R9 last entry high", v, 32'h0);
    rd_ptr(8'h05, v); chk("R9 gap reads ones", v, 32'hFFFF_FFFF);
    rd_ptr(8'h0F, v); chk("R9 gap top reads ones", v, 32'hFFFF_FFFF);
    set_ptr(past); wr_data(32'hFFFF_FFFF, er);
    chk("R9 past write no err", er, 2'b00);
    chk("R9 past write no strobe", cfg_chg, '0);
    set_ptr(8'h05); wr_data(32'hFFFF_FFFF, er);
    chk("R9 gap write no strobe", cfg_chg, '0);
    rd_ptr(past - 8'd2, v); chk("R9 last entry low intact", v, 32'h0001_0800);
  endtask

  task automatic t_strobe;
    logic [1:0] er;
    logic [N-1:0] exp1;
    exp1 = '0; exp1[5] = 1'b1;
    set_ptr(8'h1A); wr_data(32'h0000_0033, er);
    chk("R12 strobe entry5 low", cfg_chg, exp1);
    @(negedge clk); chk("R12 strobe one cycle", cfg_chg, '0);
    set_ptr(8'h1B); wr_data(32'h0100_0000, er);
    chk("R12 strobe entry5 high", cfg_chg, exp1);
    @(negedge clk); chk("R12 strobe clears", cfg_chg, '0);
  endtask

  task automatic t_rereset;
    logic [31:0] v; logic [1:0] er;
    set_ptr(8'h1A);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    xact(1'b0, 5'h00, 2'd0, 32'h0, v, er); chk("R11 selector cleared", v, 32'h0);
    rd_ptr(8'h00, v); chk("R11 id cleared", v, 32'h0);
    rd_ptr(8'h16, v); chk("R11 entry3 low restored", v, 32'h0001_0800);
    rd_ptr(8'h17, v); chk("R11 entry3 high restored", v, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    set_ptr(8'h11);
    t_offsets();
    t_selector();
    t_size();
    t_id();
    t_rev_arb();
    t_halves_mask();
    t_bounds();
    t_strobe();
    t_rereset();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule